// File: doc/BRIEF.md
# SD Card Initialization Sequencer

This block brings a freshly powered SD card into the transfer state without software involvement. After a start pulse it walks the card through software reset, the voltage and pattern check, the operating-condition handshake, identification, address assignment, the card-specific-data read, selection, block length setup and the switch to a 4-bit data bus. Each step is handed to an external command engine as one request. The request carries the command index, the 32-bit argument, the expected response kind and the CRC and index check enables. The engine answers with a completion strobe, a status code and up to four 32-bit response words.

From the answers the sequencer works out three things. It sorts the card into legacy, version-2 standard-capacity or high-capacity. It captures the 16-bit relative card address. It computes the card size in 512-byte blocks from whichever card-specific-data layout the card reports. These results are held at the outputs and are meaningful in the cycle in which `done_o` pulses. A failed step ends the run early with the not-initialized flag set.

Top module: `sd_init_seq`

## Requirements
- R1: On a card that answers every step, the commands are issued in this order: 0, 8, 55, 41 (probe), then zero or more pairs 55/41 (polling), then 2, 3, 9, 7, 16, 55, 6. Each request is a one-cycle `cmd_req_o` pulse, and the next request follows only after `cmd_done_i`.
- R2: Command 8 carries argument 0x000001AA. If status is 0 (ok) and response word 0 (`cmd_rsp_i[31:0]`) differs from 0x1AA, the run aborts. If status is 2 (no response), the card is treated as legacy and the run continues.
- R3: Every command 55 carries the current relative address in bits 31:16 and zero in bits 15:0. Before command 3 has completed, that address is zero.
- R4: The probe 41 carries argument 0. Polling happens only when the probe's word 0 has bit 21 or bit 20 set. Each poll 41 carries 0x00300000, with 0x40000000 added when command 8 was echoed. Polling stops once word 0 bit 31 is set or after POLL_MAX polls, whichever comes first, and the run then continues with command 2.
- R5: `high_cap_o` is 1 only when command 8 was echoed and the poll that returned bit 31 also returned bit 30. A poll loop that times out, or one that was never entered, gives 0.
- R6: `rca_o` is bits 31:16 of the command 3 response. Commands 9 and 7 carry that address in bits 31:16, with bits 15:0 zero.
- R7: When response bits 119:118 (word 3 bits 23:22) are 0, the block count follows the old layout. READ_BL_LEN is bits 75:72. C_SIZE is {bits 65:64, bits 63:54}. C_SIZE_MULT is bits 41:39. The count is (C_SIZE+1) << (C_SIZE_MULT+READ_BL_LEN−7), and a negative shift is clamped to 0.
- R8: When response bits 119:118 are non-zero, the block count is (bits 61:40 + 1) × 1024.
- R9: Command 16 carries argument 512, and command 6 carries argument 2.
- R10: `card_type_o` is 1 for a legacy card, 2 for a version-2 standard-capacity card, 3 for a high-capacity card, and 0 after reset or after a failed run.
- R11: Status 1 (error) on any command, or status 2 on any command other than 8, ends the run at once. No further requests are issued, `done_o` pulses and `not_init_o` stays 1.
- R12: `busy_o` rises in the cycle after `start_i` is sampled in idle and stays high through the single `done_o` cycle. `start_i` has no effect while busy.
- R13: The response kind is 0 (none) for command 0, 1 (136-bit) for commands 2 and 9, 3 (48-bit with busy) for command 7, and 2 (48-bit) otherwise. CRC checking is off only for commands 0 and 41. Index checking is on only for commands 8, 55, 3, 7, 16 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence (sampled in idle only) |
| cmd_req_o | output | 1 | One-cycle command request |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_rsp_type_o | output | 2 | Expected response kind |
| cmd_crc_chk_o | output | 1 | Response CRC check enable |
| cmd_idx_chk_o | output | 1 | Response index check enable |
| cmd_done_i | input | 1 | Command completion strobe |
| cmd_status_i | input | 2 | 0 ok, 1 error, 2 no response |
| cmd_rsp_i | input | 128 | Response words, word k at bits 32k+31:32k |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| not_init_o | output | 1 | Card not initialized |
| card_type_o | output | 2 | Card class |
| high_cap_o | output | 1 | High-capacity card |
| rca_o | output | 16 | Relative card address |
| blocks_o | output | BLK_W | Card size in 512-byte blocks |

## Verification
The hardest corner to reach is the end of the operating-condition loop: the poll that reports ready on exactly the last allowed try, next to a card that never reports ready and must be demoted to standard capacity. The bench shrinks POLL_MAX to 4 and scripts a card model that reports ready on a chosen poll number, so both edges of the loop bound are hit in a few hundred cycles. The same model sweeps the old-layout size fields over every multiplier and three block-length codes, and injects error and no-response statuses at chosen commands.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_LONG  = 2'd1,
    RSP_SHORT = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    CST_OK    = 2'd0,
    CST_ERR   = 2'd1,
    CST_NORSP = 2'd2
  } cmd_status_e;

  // order matters: the sequencer advances by increment
  typedef enum logic [3:0] {
    STP_RESET, STP_IFCOND, STP_PROBE_APP, STP_PROBE, STP_POLL_APP, STP_POLL,
    STP_IDENT, STP_ADDR, STP_CSD, STP_SELECT, STP_BLKLEN, STP_BW_APP, STP_BUSW
  } step_e;

  typedef enum logic [1:0] {
    SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT, SEQ_FINISH
  } seq_state_e;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    rsp_kind_e   rtype;
    logic        crc_chk;
    logic        idx_chk;
  } cmd_fields_t;

  localparam logic [31:0] IF_COND_ARG = 32'h0000_01AA;
  localparam logic [31:0] OCR_VOLT    = 32'h0030_0000;
  localparam logic [31:0] OCR_HCS     = 32'h4000_0000;
  localparam logic [31:0] BLK_BYTES   = 32'd512;
  localparam logic [31:0] BUS_4BIT    = 32'd2;

endpackage

// File: rtl/sdi_cmd_table.sv
module sdi_cmd_table
  import sdi_pkg::*;
(
  input  step_e       step_i,
  input  logic [15:0] rca_i,
  input  logic        v2_i,
  output cmd_fields_t cmd_o
);
  logic [31:0] rca_arg;
  assign rca_arg = {rca_i, 16'h0000};

  always_comb begin
    cmd_o = '{idx: 6'd0, arg: 32'd0, rtype: RSP_SHORT, crc_chk: 1'b1, idx_chk: 1'b1};
    unique case (step_i)
      STP_RESET: begin
        cmd_o.rtype = RSP_NONE; cmd_o.crc_chk = 1'b0; cmd_o.idx_chk = 1'b0;
      end
      STP_IFCOND: begin
        cmd_o.idx = 6'd8; cmd_o.arg = IF_COND_ARG;
      end
      STP_PROBE_APP, STP_POLL_APP, STP_BW_APP: begin
        cmd_o.idx = 6'd55; cmd_o.arg = rca_arg;
      end
      STP_PROBE, STP_POLL: begin
        cmd_o.idx = 6'd41; cmd_o.crc_chk = 1'b0; cmd_o.idx_chk = 1'b0;
        cmd_o.arg = (step_i == STP_POLL) ? (OCR_VOLT | (v2_i ? OCR_HCS : 32'd0)) : 32'd0;
      end
      STP_IDENT: begin
        cmd_o.idx = 6'd2; cmd_o.rtype = RSP_LONG; cmd_o.idx_chk = 1'b0;
      end
      STP_ADDR: cmd_o.idx = 6'd3;
      STP_CSD: begin
        cmd_o.idx = 6'd9; cmd_o.arg = rca_arg; cmd_o.rtype = RSP_LONG; cmd_o.idx_chk = 1'b0;
      end
      STP_SELECT: begin
        cmd_o.idx = 6'd7; cmd_o.arg = rca_arg; cmd_o.rtype = RSP_BUSY;
      end
      STP_BLKLEN: begin
        cmd_o.idx = 6'd16; cmd_o.arg = BLK_BYTES;
      end
      STP_BUSW: begin
        cmd_o.idx = 6'd6; cmd_o.arg = BUS_4BIT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdi_csd_decode.sv
module sdi_csd_decode #(
  parameter int BLK_W = 34
) (
  input  logic [127:0]     csd_i,
  output logic [BLK_W-1:0] blocks_o
);
  logic [1:0]  layout;
  logic [3:0]  rd_len;
  logic [11:0] sz_old;
  logic [2:0]  sz_mult;
  logic [21:0] sz_new;
  logic [4:0]  exp_sum, shamt;

  assign layout  = csd_i[119:118];
  assign rd_len  = csd_i[75:72];
  assign sz_old  = {csd_i[65:64], csd_i[63:54]};
  assign sz_mult = csd_i[41:39];
  assign sz_new  = csd_i[61:40];

  assign exp_sum = 5'(sz_mult) + 5'(rd_len);
  assign shamt   = (exp_sum < 5'd7) ? 5'd0 : exp_sum - 5'd7;

  always_comb begin
    if (layout == 2'b00) blocks_o = BLK_W'(BLK_W'(sz_old) + 1'b1) << shamt;
    else                 blocks_o = BLK_W'(BLK_W'(sz_new) + 1'b1) << 10;
  end
endmodule

// File: rtl/sdi_poll_ctr.sv
module sdi_poll_ctr #(
  parameter int MAX = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX - 1));

  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX)); // R4
endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sdi_pkg::*;
#(
  parameter int POLL_MAX = 100000,
  parameter int BLK_W    = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             cmd_req_o,
  output logic [5:0]       cmd_idx_o,
  output logic [31:0]      cmd_arg_o,
  output logic [1:0]       cmd_rsp_type_o,
  output logic             cmd_crc_chk_o,
  output logic             cmd_idx_chk_o,
  input  logic             cmd_done_i,
  input  logic [1:0]       cmd_status_i,
  input  logic [127:0]     cmd_rsp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             not_init_o,
  output logic [1:0]       card_type_o,
  output logic             high_cap_o,
  output logic [15:0]      rca_o,
  output logic [BLK_W-1:0] blocks_o
);
  seq_state_e       state_q;
  step_e            step_q, nx_step;
  logic             v2_q, hc_q, not_init_q;
  logic [15:0]      rca_q;
  logic [BLK_W-1:0] blocks_q, csd_blocks;
  cmd_fields_t      cmd;
  logic [31:0]      rsp0;
  logic             st_ok, st_norsp, accept, abort, finish_ok;
  logic             poll_clr, poll_inc, poll_last;

  assign rsp0     = cmd_rsp_i[31:0];
  assign st_ok    = (cmd_status_i == CST_OK);
  assign st_norsp = (cmd_status_i == CST_NORSP);
  assign accept   = (state_q == SEQ_WAIT) && cmd_done_i;

  sdi_cmd_table u_table (
    .step_i(step_q), .rca_i(rca_q), .v2_i(v2_q), .cmd_o(cmd)
  );

  sdi_csd_decode #(.BLK_W(BLK_W)) u_csd (
    .csd_i(cmd_rsp_i), .blocks_o(csd_blocks)
  );

  sdi_poll_ctr #(.MAX(POLL_MAX)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(accept && poll_clr), .inc_i(accept && poll_inc), .last_o(poll_last)
  );

  // per-step outcome of a completed command
  always_comb begin
    nx_step   = step_e'(4'(step_q) + 4'd1);
    abort     = !st_ok;
    finish_ok = 1'b0;
    poll_clr  = 1'b0;
    poll_inc  = 1'b0;
    unique case (step_q)
      STP_IFCOND: begin
        if (st_norsp) abort = 1'b0;
        else if (st_ok && rsp0 != IF_COND_ARG) abort = 1'b1;
      end
      STP_PROBE: begin
        if (rsp0[21:20] == 2'b00) nx_step = STP_IDENT;
        else poll_clr = 1'b1;
      end
      STP_POLL: begin
        poll_inc = 1'b1;
        if (!rsp0[31] && !poll_last) nx_step = STP_POLL_APP;
      end
      STP_BUSW: finish_ok = st_ok;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      step_q     <= STP_RESET;
      v2_q       <= 1'b0;
      hc_q       <= 1'b0;
      not_init_q <= 1'b1;
      rca_q      <= '0;
      blocks_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q    <= SEQ_ISSUE;
          step_q     <= STP_RESET;
          v2_q       <= 1'b0;
          hc_q       <= 1'b0;
          not_init_q <= 1'b1;
          rca_q      <= '0;
          blocks_q   <= '0;
        end
        SEQ_ISSUE: state_q <= SEQ_WAIT;
        SEQ_WAIT: if (cmd_done_i) begin
          if (abort) state_q <= SEQ_FINISH;
          else begin
            step_q <= nx_step;
            if (finish_ok) begin
              state_q    <= SEQ_FINISH;
              not_init_q <= 1'b0;
            end else state_q <= SEQ_ISSUE;
            unique case (step_q)
              STP_IFCOND: v2_q <= st_ok;
              STP_POLL:   if (rsp0[31]) hc_q <= v2_q & rsp0[30];
              STP_ADDR:   rca_q <= rsp0[31:16];
              STP_CSD:    blocks_q <= csd_blocks;
              default: ;
            endcase
          end
        end
        SEQ_FINISH: state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign cmd_req_o      = (state_q == SEQ_ISSUE);
  assign cmd_idx_o      = cmd.idx;
  assign cmd_arg_o      = cmd.arg;
  assign cmd_rsp_type_o = cmd.rtype;
  assign cmd_crc_chk_o  = cmd.crc_chk;
  assign cmd_idx_chk_o  = cmd.idx_chk;

  assign busy_o      = (state_q != SEQ_IDLE);
  assign done_o      = (state_q == SEQ_FINISH);
  assign not_init_o  = not_init_q;
  assign high_cap_o  = hc_q & ~not_init_q;
  assign rca_o       = rca_q;
  assign blocks_o    = blocks_q;
  assign card_type_o = not_init_q ? 2'd0 : (!v2_q ? 2'd1 : (hc_q ? 2'd3 : 2'd2));

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |-> busy_o); // R12
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R12
  AST_APP_ARG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && cmd_idx_o == 6'd55 |-> cmd_arg_o[15:0] == 16'h0); // R3
  AST_IFCOND_ARG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o && cmd_idx_o == 6'd8 |-> cmd_arg_o == IF_COND_ARG); // R2
  AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cmd_status_i == CST_ERR |=> done_o && not_init_o && !cmd_req_o); // R11
  AST_FAIL_NO_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && not_init_o |-> card_type_o == 2'd0 && !high_cap_o); // R10
endmodule

// File: tb/tb_sd_init_seq.sv
module tb_sd_init_seq;
  localparam int PM = 4;
  localparam int BW = 34;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #5 clk = ~clk;

  logic req, crc_c, idx_c, busy, done, nin, hc;
  logic [5:0] idx; logic [31:0] arg; logic [1:0] rt, ctype;
  logic done_in = 1'b0; logic [1:0] st_in = 2'd0; logic [127:0] rsp_in = '0;
  logic [15:0] rca; logic [BW-1:0] blks;

  sd_init_seq #(.POLL_MAX(PM), .BLK_W(BW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cmd_req_o(req), .cmd_idx_o(idx), .cmd_arg_o(arg), .cmd_rsp_type_o(rt),
    .cmd_crc_chk_o(crc_c), .cmd_idx_chk_o(idx_c),
    .cmd_done_i(done_in), .cmd_status_i(st_in), .cmd_rsp_i(rsp_in),
    .busy_o(busy), .done_o(done), .not_init_o(nin), .card_type_o(ctype),
    .high_cap_o(hc), .rca_o(rca), .blocks_o(blks)
  );

  int n_chk = 0, n_fail = 0;

  // card model settings
  int cmd8_mode; logic [31:0] probe_rsp; int ready_after; bit hc_bit;
  logic [15:0] card_rca; logic [127:0] csd; int fail_idx; logic [1:0] fail_st;
  bit poke_start; longint e_blk;

  logic [5:0] log_idx[64]; logic [31:0] log_arg[64]; logic [1:0] log_rt[64];
  logic log_crc[64], log_ic[64]; int n_log;
  logic [5:0] e_idx[64]; logic [31:0] e_arg[64]; int n_exp; bit e_stop, e_fail;
  logic [1:0] r_type; logic r_hc, r_nin, r_busy; logic [15:0] r_rca; logic [BW-1:0] r_blk;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [5:0] c);
    case (c)
      6'd8: return "R2"; 6'd55: return "R3"; 6'd41: return "R4";
      6'd9, 6'd7, 6'd3: return "R6"; 6'd16, 6'd6: return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [127:0] csd_old(int cs, int mult, int rbl);
    logic [127:0] c = '0;
    logic [11:0] s = 12'(cs);
    c[127:120] = 8'h5A; c[75:72] = 4'(rbl); c[65:64] = s[11:10];
    c[63:54] = s[9:0]; c[41:39] = 3'(mult);
    return c;
  endfunction

  function automatic logic [127:0] csd_new(int cs);
    logic [127:0] c = '0;
    c[119:118] = 2'b01; c[61:40] = 22'(cs); c[7:0] = 8'hA5;
    return c;
  endfunction

  task automatic push(logic [5:0] c, logic [31:0] a);
    if (!e_stop) begin
      e_idx[n_exp] = c; e_arg[n_exp] = a; n_exp++;
      if (int'(c) == fail_idx) begin e_stop = 1; e_fail = 1; end
    end
  endtask

  task automatic build_exp();
    bit v2 = (cmd8_mode == 0);
    logic [31:0] ra = {card_rca, 16'h0};
    n_exp = 0; e_stop = 0; e_fail = 0;
    push(6'd0, 32'd0); push(6'd8, 32'h1AA);
    if (cmd8_mode == 1) begin e_stop = 1; e_fail = 1; end
    push(6'd55, 32'd0); push(6'd41, 32'd0);
    if (probe_rsp[21:20] != 2'b00)
      for (int k = 1; k <= PM; k++) begin
        push(6'd55, 32'd0);
        push(6'd41, 32'h0030_0000 | (v2 ? 32'h4000_0000 : 32'd0));
        if (ready_after != 0 && k >= ready_after) break;
      end
    push(6'd2, 32'd0); push(6'd3, 32'd0); push(6'd9, ra); push(6'd7, ra);
    push(6'd16, 32'd512); push(6'd55, ra); push(6'd6, 32'd2);
  endtask

  task automatic set_default();
    cmd8_mode = 0; probe_rsp = 32'h00FF_8000; ready_after = 2; hc_bit = 1;
    card_rca = 16'hB368; csd = csd_new(12345); e_blk = 64'(12346) * 1024;
    fail_idx = -1; fail_st = 2'd1; poke_start = 0;
  endtask

  task automatic run_check();
    int cyc = 0, polls = 0;
    bit got = 0, v2, hcx, rdy;
    logic [1:0] et;
    n_log = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (!got && cyc < 5000) begin
      if (done) begin
        got = 1; r_type = ctype; r_hc = hc; r_nin = nin; r_rca = rca; r_blk = blks; r_busy = busy;
      end else if (req) begin
        logic [127:0] r = '0; logic [1:0] s = 2'd0;
        log_idx[n_log] = idx; log_arg[n_log] = arg; log_rt[n_log] = rt;
        log_crc[n_log] = crc_c; log_ic[n_log] = idx_c; n_log++;
        case (idx)
          6'd8: if (cmd8_mode == 0) r[31:0] = 32'h1AA;
                else if (cmd8_mode == 1) r[31:0] = 32'h1AB; else s = 2'd2;
          6'd41: if (arg == 0) r[31:0] = probe_rsp;
                 else begin
                   polls++;
                   if (ready_after != 0 && polls >= ready_after)
                     r[31:0] = 32'h80FF_8000 | (hc_bit ? 32'h4000_0000 : 32'd0);
                   else r[31:0] = 32'h40FF_8000;
                 end
          6'd3: r[31:0] = {card_rca, 16'h0500};
          6'd9: r = csd;
          6'd55: r[31:0] = 32'h0000_0120;
          default: ;
        endcase
        if (int'(idx) == fail_idx) s = fail_st;
        @(negedge clk);
        done_in = 1; st_in = s; rsp_in = r; start = poke_start;
        @(negedge clk);
        done_in = 0; start = 0; rsp_in = '0; st_in = 2'd0;
      end else @(negedge clk);
      cyc++;
    end
    chk(got, "R12", "done pulse seen", got, 1);
    chk(r_busy, "R12", "busy during done", r_busy, 1);
    @(negedge clk);
    chk(!busy && !done, "R12", "idle after done", {busy, done}, 0);
    build_exp();
    chk(n_log == n_exp, "R1", "command count", n_log, n_exp);
    for (int i = 0; i < n_log && i < n_exp; i++) begin
      chk(log_idx[i] == e_idx[i], "R1", $sformatf("cmd %0d index", i), log_idx[i], e_idx[i]);
      chk(log_arg[i] == e_arg[i], tag_of(e_idx[i]), $sformatf("cmd %0d arg", i), log_arg[i], e_arg[i]);
      // R13 expected kinds and check enables
      case (log_idx[i]) 6'd0: et = 2'd0; 6'd2, 6'd9: et = 2'd1; 6'd7: et = 2'd3; default: et = 2'd2; endcase
      chk(log_rt[i] == et, "R13", "response kind", log_rt[i], et);
      chk(log_crc[i] == !(log_idx[i] inside {6'd0, 6'd41}), "R13", "crc enable", log_crc[i], !log_crc[i]);
      chk(log_ic[i] == (log_idx[i] inside {6'd8, 6'd55, 6'd3, 6'd7, 6'd16, 6'd6}), "R13", "index enable",
          log_ic[i], !log_ic[i]);
    end
    v2  = (cmd8_mode == 0);
    rdy = (probe_rsp[21:20] != 2'b00) && ready_after != 0 && ready_after <= PM;
    hcx = v2 && rdy && hc_bit;
    chk(r_nin == e_fail, "R11", "not-init flag", r_nin, e_fail);
    et = e_fail ? 2'd0 : (!v2 ? 2'd1 : (hcx ? 2'd3 : 2'd2));
    chk(r_type == et, "R10", "card type", r_type, et);
    chk(r_hc == (hcx && !e_fail), "R5", "high capacity", r_hc, hcx && !e_fail);
    if (!e_fail) begin
      chk(r_rca == card_rca, "R6", "relative address", r_rca, card_rca);
      chk(r_blk == BW'(e_blk), (csd[119:118] == 0) ? "R7" : "R8", "block count", r_blk, e_blk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req, "R12", "reset idle", {busy, done, req}, 0);
    chk(nin && ctype == 2'd0 && !hc, "R10", "reset result", {nin, ctype, hc}, 3'b100);
    rst_n = 1;
    // high capacity, restart attempt mid-run ignored (R12)
    set_default(); poke_start = 1; run_check();
    // old layout sweep, standard capacity (R7)
    for (int m = 0; m < 8; m++)
      for (int b = 9; b < 12; b++) begin
        int cs = (m * 517 + b * 91) & 12'hFFF;
        set_default(); hc_bit = 0; csd = csd_old(cs, m, b);
        e_blk = longint'(cs + 1) << (m + b - 7); run_check();
      end
    set_default(); hc_bit = 0; csd = csd_old(4095, 7, 11); e_blk = 64'd4096 << 11; run_check();
    set_default(); hc_bit = 0; csd = csd_old(10, 0, 5); e_blk = 64'd11; run_check();
    // new layout extremes (R8)
    for (int j = 0; j < 3; j++) begin
      int cs = (j == 0) ? 0 : ((j == 1) ? 22'h3FFFFF : 7777);
      set_default(); csd = csd_new(cs); e_blk = (longint'(cs) + 1) * 1024; run_check();
    end
    // legacy card: no response to command 8 (R2)
    set_default(); cmd8_mode = 2; card_rca = 16'h0001; run_check();
    // echo mismatch aborts (R2)
    set_default(); cmd8_mode = 1; run_check();
    // poll ready on last allowed try, and never ready (R4, R5)
    set_default(); ready_after = PM; run_check();
    set_default(); ready_after = 0; run_check();
    set_default(); ready_after = 1; hc_bit = 0; run_check();
    // probe without voltage bits skips polling (R4)
    set_default(); probe_rsp = 32'h000F_8000; run_check();
    // failures mid-sequence (R11)
    set_default(); fail_idx = 9; fail_st = 2'd1; run_check();
    set_default(); fail_idx = 3; fail_st = 2'd2; run_check();
    set_default(); fail_idx = 16; fail_st = 2'd1; run_check();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule